// File: doc/BRIEF.md
# Bus Thread Presence Tracker

This block sits beside a front-side processor bus and keeps a record of which processor threads have driven at least one bus cycle since reset. Every valid observed cycle carries two index fields. Bits 6:5 of the deferred-reply identifier select the processor. Bits 6:5 of the attribute field select the thread within that processor. The pair picks one sticky bit in a 64-bit presence vector. The bit stays set until reset.

Firmware reads the vector before starting a measured launch so it can confirm that every expected thread has shown itself on the bus. When a secure-launch message appears on the bus, the vector freezes. From that point no later bus traffic can change what software reads. Only reset releases the freeze.

The vector is reached through a simple read port. A read is requested with a one-cycle strobe and answered on the next cycle.

Top module: `bus_thread_tracker`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, the presence vector is all zeros, the lock is clear and `rd_valid` is low.
- R2: A cycle with `obs_valid` high sets bit `cpu*8 + thr` of the vector at the next rising clock edge. Here `cpu` is `obs_tag[6:5]` and `thr` is `obs_attr[6:5]`.
- R3: The bits of `obs_tag` and `obs_attr` outside positions 6:5 have no effect on which bit is set.
- R4: A set presence bit stays set until reset, whatever later traffic appears.
- R5: Bits 63:32 of the vector always read zero, and so do bits 4 to 7 of each processor's byte.
- R6: A cycle with both `obs_valid` and `obs_launch` high locks the vector. From the following clock edge onward, observed cycles set no further bits.
- R7: The cycle that carries the launch message is itself recorded, because the lock takes effect only from the next clock edge.
- R8: Once set, the lock stays set through any later traffic, including further launch messages, and only reset clears it. After reset the vector records cycles again.
- R9: When `rd_en` is high at a rising edge, `rd_data` shows the vector as it was just before that edge, and `rd_valid` is high in the following cycle. Without `rd_en`, `rd_data` holds its value and `rd_valid` is low. A read never changes the vector.
- R10: When `obs_valid` is low, the tag, attribute and launch inputs are ignored. No bit is set and no lock occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| obs_valid | input | 1 | An observed bus cycle is present this clock |
| obs_tag | input | 8 | Deferred-reply identifier of the cycle; bits 6:5 give the processor |
| obs_attr | input | 8 | Attribute field of the cycle; bits 6:5 give the thread |
| obs_launch | input | 1 | The observed cycle is a secure-launch message |
| rd_en | input | 1 | Read strobe for the presence vector |
| rd_data | output | 64 | Presence vector returned by the last read |
| rd_valid | output | 1 | `rd_data` was refreshed at the last edge |

## Verification
The bench drives traffic into all sixteen processor and thread slots, with the unused tag and attribute bits toggled. A decoder that took the wrong slice, swapped the two fields or used a byte lane of the wrong width would set bits the bench does not expect. It puts a launch message and a cycle from a new thread in the same clock, and sends cycles after the lock. A lock that acts one clock too early drops the launch cycle, and a missing or non-sticky lock lets later cycles leak into the vector. It also pairs a read with a cycle in the same clock and drives a launch indication with `obs_valid` low. A read port with the wrong latency would show up in the first case, and a tracker that ignored the valid qualifier would set a bit or lock in the second.

// File: rtl/btp_pkg.sv
package btp_pkg;
  localparam int unsigned BTP_CPU_NUM  = 4;
  localparam int unsigned BTP_THR_NUM  = 4;
  localparam int unsigned BTP_LANE_W   = 8;
  localparam int unsigned BTP_VEC_W    = 64;
  localparam int unsigned BTP_FIELD_W  = 8;
  localparam int unsigned BTP_IDX_LSB  = 5;

  typedef logic [BTP_VEC_W-1:0] btp_vec_t;
endpackage

// File: rtl/btp_decode.sv
module btp_decode #(
  parameter int unsigned CPU_NUM = btp_pkg::BTP_CPU_NUM,
  parameter int unsigned THR_NUM = btp_pkg::BTP_THR_NUM,
  parameter int unsigned LANE_W  = btp_pkg::BTP_LANE_W,
  parameter int unsigned VEC_W   = btp_pkg::BTP_VEC_W,
  parameter int unsigned FIELD_W = btp_pkg::BTP_FIELD_W,
  parameter int unsigned IDX_LSB = btp_pkg::BTP_IDX_LSB
) (
  input  logic               obs_valid,
  input  logic [FIELD_W-1:0] obs_tag,
  input  logic [FIELD_W-1:0] obs_attr,
  input  logic               obs_launch,
  output logic [VEC_W-1:0]   set_mask,
  output logic               launch_hit
);
  localparam int unsigned CPU_IDX_W = (CPU_NUM > 1) ? $clog2(CPU_NUM) : 1;
  localparam int unsigned THR_IDX_W = (THR_NUM > 1) ? $clog2(THR_NUM) : 1;

  logic [CPU_IDX_W-1:0] cpu_idx;
  logic [THR_IDX_W-1:0] thr_idx;
  logic                 unused_fields;

  assign cpu_idx       = obs_tag[IDX_LSB +: CPU_IDX_W];
  assign thr_idx       = obs_attr[IDX_LSB +: THR_IDX_W];
  assign unused_fields = ^{obs_tag, obs_attr};
  assign launch_hit    = obs_valid & obs_launch;

  for (genvar i = 0; i < VEC_W; i++) begin : g_bit
    localparam int unsigned LANE = i / LANE_W;
    localparam int unsigned POS  = i % LANE_W;
    if (LANE < CPU_NUM && POS < THR_NUM) begin : g_live
      assign set_mask[i] = obs_valid &&
                           (cpu_idx == CPU_IDX_W'(LANE)) &&
                           (thr_idx == THR_IDX_W'(POS));
    end else begin : g_rsvd
      assign set_mask[i] = 1'b0;
    end
  end
endmodule

// File: rtl/btp_presence_reg.sv
module btp_presence_reg #(
  parameter int unsigned VEC_W = btp_pkg::BTP_VEC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VEC_W-1:0] set_mask,
  input  logic             launch_hit,
  output logic [VEC_W-1:0] vec_q,
  output logic             lock_q
);
  logic [VEC_W-1:0] vec_d;
  logic             lock_d;
  logic             vec_en;

  always_comb begin
    vec_en = !lock_q && (set_mask != '0);
    vec_d  = vec_q | set_mask;
    lock_d = lock_q | launch_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q  <= '0;
      lock_q <= 1'b0;
    end else begin
      if (vec_en) vec_q <= vec_d;
      lock_q <= lock_d;
    end
  end
endmodule

// File: rtl/btp_read_port.sv
module btp_read_port #(
  parameter int unsigned VEC_W = btp_pkg::BTP_VEC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_en,
  input  logic [VEC_W-1:0] vec,
  output logic [VEC_W-1:0] rd_data,
  output logic             rd_valid
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      if (rd_en) rd_data <= vec;
      rd_valid <= rd_en;
    end
  end
endmodule

// File: rtl/bus_thread_tracker.sv
module bus_thread_tracker #(
  parameter int unsigned CPU_NUM = btp_pkg::BTP_CPU_NUM,
  parameter int unsigned THR_NUM = btp_pkg::BTP_THR_NUM,
  parameter int unsigned LANE_W  = btp_pkg::BTP_LANE_W,
  parameter int unsigned VEC_W   = btp_pkg::BTP_VEC_W,
  parameter int unsigned FIELD_W = btp_pkg::BTP_FIELD_W,
  parameter int unsigned IDX_LSB = btp_pkg::BTP_IDX_LSB
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               obs_valid,
  input  logic [FIELD_W-1:0] obs_tag,
  input  logic [FIELD_W-1:0] obs_attr,
  input  logic               obs_launch,
  input  logic               rd_en,
  output logic [VEC_W-1:0]   rd_data,
  output logic               rd_valid
);
  logic [VEC_W-1:0] set_mask;
  logic             launch_hit;
  logic [VEC_W-1:0] pres_vec;
  logic             lock_flag;

  btp_decode #(
    .CPU_NUM(CPU_NUM), .THR_NUM(THR_NUM), .LANE_W(LANE_W),
    .VEC_W(VEC_W), .FIELD_W(FIELD_W), .IDX_LSB(IDX_LSB)
  ) dec_i (
    .obs_valid (obs_valid),
    .obs_tag   (obs_tag),
    .obs_attr  (obs_attr),
    .obs_launch(obs_launch),
    .set_mask  (set_mask),
    .launch_hit(launch_hit)
  );

  btp_presence_reg #(.VEC_W(VEC_W)) pres_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_mask  (set_mask),
    .launch_hit(launch_hit),
    .vec_q     (pres_vec),
    .lock_q    (lock_flag)
  );

  btp_read_port #(.VEC_W(VEC_W)) rd_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_en   (rd_en),
    .vec     (pres_vec),
    .rd_data (rd_data),
    .rd_valid(rd_valid)
  );
endmodule

// File: rtl/btp_chk.sv
module btp_chk #(
  parameter int unsigned CPU_NUM = btp_pkg::BTP_CPU_NUM,
  parameter int unsigned THR_NUM = btp_pkg::BTP_THR_NUM,
  parameter int unsigned LANE_W  = btp_pkg::BTP_LANE_W,
  parameter int unsigned VEC_W   = btp_pkg::BTP_VEC_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             obs_valid,
  input logic             obs_launch,
  input logic             rd_en,
  input logic [VEC_W-1:0] rd_data,
  input logic             rd_valid,
  input logic [VEC_W-1:0] pres_vec,
  input logic             lock_flag
);
  function automatic logic [VEC_W-1:0] live_mask();
    logic [VEC_W-1:0] m;
    m = '0;
    for (int i = 0; i < int'(VEC_W); i++)
      if ((i / LANE_W) < CPU_NUM && (i % LANE_W) < THR_NUM) m[i] = 1'b1;
    return m;
  endfunction

  localparam logic [VEC_W-1:0] LIVE = live_mask();

  // R5
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pres_vec & ~LIVE) == '0) && ((rd_data & ~LIVE) == '0));

  // R4
  sticky_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pres_vec & $past(pres_vec)) == $past(pres_vec)));

  // R6
  frozen_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_flag |=> $stable(pres_vec));

  // R8
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_flag |=> lock_flag);

  // R9
  rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> (rd_valid && rd_data == $past(pres_vec)));

  // R9
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> (!rd_valid && $stable(rd_data)));

  // R10
  idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !obs_valid |=> ($stable(pres_vec) && $stable(lock_flag)));

  // R6
  launch_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (obs_valid && obs_launch) |=> lock_flag);
endmodule

bind bus_thread_tracker btp_chk #(
  .CPU_NUM(CPU_NUM), .THR_NUM(THR_NUM), .LANE_W(LANE_W), .VEC_W(VEC_W)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .obs_valid (obs_valid),
  .obs_launch(obs_launch),
  .rd_en     (rd_en),
  .rd_data   (rd_data),
  .rd_valid  (rd_valid),
  .pres_vec  (pres_vec),
  .lock_flag (lock_flag)
);

// File: tb/bus_thread_tracker_tb_top.sv
`timescale 1ns/1ps
module bus_thread_tracker_tb_top;
  logic        clk;
  logic        rst_n;
  logic        obs_valid;
  logic [7:0]  obs_tag;
  logic [7:0]  obs_attr;
  logic        obs_launch;
  logic        rd_en;
  logic [63:0] rd_data;
  logic        rd_valid;

  int n_tests;
  int n_fail;
  bit done;
  logic [63:0] exp_vec;

  bus_thread_tracker dut_i (
    .clk(clk), .rst_n(rst_n), .obs_valid(obs_valid), .obs_tag(obs_tag),
    .obs_attr(obs_attr), .obs_launch(obs_launch), .rd_en(rd_en),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check64(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check1(input string req, input logic act, input logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // one bus cycle; junk fills bits outside 6:5 of both fields
  task automatic bus_cycle(input int cpu, input int thr, input bit launch, input logic [7:0] junk);
    @(negedge clk);
    obs_valid  = 1'b1;
    obs_tag    = (junk & 8'h9F) | 8'(cpu << 5);
    obs_attr   = (~junk & 8'h9F) | 8'(thr << 5);
    obs_launch = launch;
    @(negedge clk);
    obs_valid  = 1'b0;
    obs_launch = 1'b0;
  endtask

  task automatic read_vec(output logic [63:0] v, output logic vld);
    @(negedge clk);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    v   = rd_data;
    vld = rd_valid;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    exp_vec = '0;
  endtask

  task automatic t_reset();
    logic [63:0] v; logic vld;
    do_reset();
    check1("R1 rd_valid after reset", rd_valid, 1'b0);
    check64("R1 rd_data after reset", rd_data, 64'h0);
    read_vec(v, vld);
    check64("R1 vector zero", v, 64'h0);
    check1("R9 rd_valid on read", vld, 1'b1);
    @(negedge clk);
    check1("R9 rd_valid drops", rd_valid, 1'b0);
    check64("R9 rd_data holds", rd_data, 64'h0);
  endtask

  task automatic t_all_slots();
    logic [63:0] v; logic vld;
    for (int c = 0; c < 4; c++) begin
      for (int t = 0; t < 4; t++) begin
        bus_cycle(c, t, 1'b0, 8'((c * 37 + t * 91) ^ 8'hA5));
        exp_vec[c*8 + t] = 1'b1;
        read_vec(v, vld);
        check64($sformatf("R2 R3 slot cpu%0d thr%0d", c, t), v, exp_vec);
      end
    end
    check64("R5 lanes upper nibble and top half zero", v & 64'hFFFF_FFFF_F0F0_F0F0, 64'h0);
  endtask

  task automatic t_sticky_repeat();
    logic [63:0] v; logic vld;
    do_reset();
    bus_cycle(2, 1, 1'b0, 8'hFF);
    exp_vec[17] = 1'b1;
    bus_cycle(2, 1, 1'b0, 8'h00);
    bus_cycle(0, 3, 1'b0, 8'h5A);
    exp_vec[3] = 1'b1;
    read_vec(v, vld);
    check64("R4 bits persist", v, exp_vec);
    read_vec(v, vld);
    check64("R9 read leaves vector intact", v, exp_vec);
  endtask

  task automatic t_idle_inputs();
    logic [63:0] v; logic vld;
    @(negedge clk);
    obs_valid = 1'b0; obs_tag = 8'h60; obs_attr = 8'h60; obs_launch = 1'b1;
    @(negedge clk);
    obs_launch = 1'b0;
    bus_cycle(3, 3, 1'b0, 8'h00);
    exp_vec[27] = 1'b1;
    read_vec(v, vld);
    check64("R10 invalid cycle ignored and no lock", v, exp_vec);
  endtask

  task automatic t_read_overlap();
    logic [63:0] v;
    @(negedge clk);
    obs_valid = 1'b1; obs_tag = 8'h20; obs_attr = 8'h40; obs_launch = 1'b0;
    rd_en = 1'b1;
    @(negedge clk);
    obs_valid = 1'b0; rd_en = 1'b0;
    v = rd_data;
    check64("R9 read shows vector before edge", v, exp_vec);
    exp_vec[10] = 1'b1;
    @(negedge clk);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    check64("R9 next read shows update", rd_data, exp_vec);
  endtask

  task automatic t_launch();
    logic [63:0] v; logic vld;
    do_reset();
    bus_cycle(0, 0, 1'b0, 8'h11);
    exp_vec[0] = 1'b1;
    bus_cycle(1, 2, 1'b1, 8'h22);
    exp_vec[10] = 1'b1;
    read_vec(v, vld);
    check64("R7 launch cycle recorded", v, exp_vec);
    bus_cycle(3, 1, 1'b0, 8'h33);
    bus_cycle(2, 2, 1'b1, 8'h44);
    bus_cycle(0, 1, 1'b0, 8'h55);
    read_vec(v, vld);
    check64("R6 R8 locked vector frozen", v, exp_vec);
    do_reset();
    read_vec(v, vld);
    check64("R8 reset clears vector", v, 64'h0);
    bus_cycle(3, 1, 1'b0, 8'h66);
    exp_vec[25] = 1'b1;
    read_vec(v, vld);
    check64("R8 recording resumes after reset", v, exp_vec);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    n_tests = 0; n_fail = 0; done = 1'b0; exp_vec = '0;
    rst_n = 1'b0; obs_valid = 1'b0; obs_tag = '0; obs_attr = '0;
    obs_launch = 1'b0; rd_en = 1'b0;
    t_reset();
    t_all_slots();
    t_sticky_repeat();
    t_idle_inputs();
    t_read_overlap();
    t_launch();
    repeat (2) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule